// File: doc/BRIEF.md
# GPIO Function-Select and Output Register Bank

This block is a memory-mapped GPIO core for 54 pins. The pins are grouped into two 32-bit banks, and pin p sits in bank p/32 at bit p%32. Each pin has a 3-bit function code that makes it a GPIO input, a GPIO output or one of six alternate functions. The codes are packed ten to a 32-bit word. For pins in GPIO-output mode the block drives the pad output enable and the pad output value. For pins given to an alternate function it raises a per-pin "alternate selected" flag, so that routing logic elsewhere can claim the pad.

Software never changes an output with a read-modify-write. Each bank has one write-one-to-set register and one write-one-to-clear register, so two agents can drive different pins with no lock between them. The pad inputs pass through a two-flop synchroniser, and a read-only level register per bank returns them.

The bus is a plain synchronous register port: a byte address, a write strobe, write data and registered read data.

Top module: `gpfs_core`

## Requirements
- R1: After reset every function code is 000 (GPIO input) and every output latch is 0, so the function words read 0 and pad_oe, pad_out and alt_sel are all zero.
- R2: The function code of pin p occupies bits (p%10)*3+2 down to (p%10)*3 of the function word at byte offset 4*(p/10), for offsets 0x00 to 0x14. A code that is written reads back unchanged.
- R3: pad_oe[p] is 1 exactly when pin p holds code 001. pad_oe, pad_out and alt_sel change only in the cycle after a bus write.
- R4: alt_sel[p] is 1 exactly when pin p holds an alternate code. The alternate codes are 100, 101, 110, 111, 011 and 010, for alternates 0 to 5. Codes 000 and 001 give 0.
- R5: A write to 0x1C (pins 0-31) or 0x20 (pins 32-53) sets the output latch of every pin whose data bit is 1. Bits written as 0 have no effect.
- R6: A write to 0x28 (pins 0-31) or 0x2C (pins 32-53) clears the output latch of every pin whose data bit is 1. Bits written as 0 have no effect.
- R7: pad_out[p] equals the pin's output latch while the pin holds code 001 and is 0 otherwise. The latch keeps its value through any other code, so a value loaded beforehand appears as soon as the pin becomes an output.
- R8: The level words at 0x34 (pins 0-31) and 0x38 (pins 32-53) return pad_in bit p at bit p%32, taken through two synchroniser flops. A pad change shows in bus_rdata after three rising edges, counting the two synchroniser stages and the read register.
- R9: bus_rdata holds the register at the address presented on the previous edge. The following all read as 0: the set and clear registers, unmapped or unaligned addresses, bits 30-31 of every function word, the fields above pin 53 in the last function word, and bits 22-31 of the bank-1 level word.
- R10: Writes to the level words, to unmapped addresses or to unaligned addresses change no function code and no output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 54 | Sampled pad levels |
| pad_out | output | 54 | Pad output values |
| pad_oe | output | 54 | Pad output enables |
| alt_sel | output | 54 | Pin is assigned to an alternate function |

## Verification
The bench builds the block at its default parameters: 54 pins, 32-bit words and ten fields per function word. This gives a second bank that is only partly populated and a last function word with four live fields. Those defaults bring the zero-read reserved bits and the bank-1 offset of the set and clear registers within reach. A code pattern spread over all pins exercises every function code, including the out-of-order alternate encodings. Latches are preloaded while pins sit in input or alternate mode and then switched to output, which exercises the preload path.

// File: rtl/gpfs_pkg.sv
package gpfs_pkg;

    // Width of one function field.
    localparam int FN_W = 3;

    // Function codes. The alternate numbering does not follow the code value.
    typedef enum logic [FN_W-1:0] {
        FN_GPIO_IN  = 3'b000,
        FN_GPIO_OUT = 3'b001,
        FN_ALT5     = 3'b010,
        FN_ALT4     = 3'b011,
        FN_ALT0     = 3'b100,
        FN_ALT1     = 3'b101,
        FN_ALT2     = 3'b110,
        FN_ALT3     = 3'b111
    } fn_code_e;

    // Byte offsets of the register groups. Software decodes these.
    localparam logic [7:0] OFS_FUNC  = 8'h00;
    localparam logic [7:0] OFS_SET   = 8'h1C;
    localparam logic [7:0] OFS_CLR   = 8'h28;
    localparam logic [7:0] OFS_LEVEL = 8'h34;

endpackage

// File: rtl/gpfs_func_bank.sv
module gpfs_func_bank
    import gpfs_pkg::*;
#(
    parameter int NUM_PINS   = 54,
    parameter int DATA_W     = 32,
    parameter int PPW        = 10,
    parameter int NUM_FWORDS = 6,
    parameter int WIDX_W     = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [WIDX_W-1:0]            wr_word,
    input  logic [PPW*FN_W-1:0]          wr_fields,
    output logic [NUM_FWORDS*DATA_W-1:0] rd_words,
    output logic [NUM_PINS-1:0]          oe_mask,
    output logic [NUM_PINS-1:0]          alt_mask
);

    localparam int FIELD_BITS = PPW * FN_W;

    logic [NUM_PINS*FN_W-1:0] codes_q;

    // Each pin's field is written only by a write to its own word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            codes_q <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_word == WIDX_W'(p / PPW)) begin
                    codes_q[p*FN_W +: FN_W] <= wr_fields[(p % PPW)*FN_W +: FN_W];
                end
            end
        end
    end

    // Per-pin mode decode.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
        logic [FN_W-1:0] code;
        assign code        = codes_q[p*FN_W +: FN_W];
        assign oe_mask[p]  = (code == FN_GPIO_OUT);
        assign alt_mask[p] = (code != FN_GPIO_IN) && (code != FN_GPIO_OUT);
    end

    // Readback words. Absent pins and spare bits read as zero.
    for (genvar w = 0; w < NUM_FWORDS; w++) begin : g_word
        for (genvar k = 0; k < PPW; k++) begin : g_field
            if (w*PPW + k < NUM_PINS) begin : g_live
                assign rd_words[w*DATA_W + k*FN_W +: FN_W] = codes_q[(w*PPW + k)*FN_W +: FN_W];
            end else begin : g_absent
                assign rd_words[w*DATA_W + k*FN_W +: FN_W] = '0;
            end
        end
        if (DATA_W > FIELD_BITS) begin : g_spare
            assign rd_words[w*DATA_W + FIELD_BITS +: DATA_W - FIELD_BITS] = '0;
        end
    end

endmodule

// File: rtl/gpfs_out_latch.sv
module gpfs_out_latch #(
    parameter int NUM_PINS = 54,
    parameter int DATA_W   = 32,
    parameter int WIDX_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [WIDX_W-1:0]   bank,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] latch_q
);

    // Only bits written as 1 act. A write of 0 leaves the latch alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (bank == WIDX_W'(p / DATA_W) && wdata[p % DATA_W]) begin
                    if (set_en) begin
                        latch_q[p] <= 1'b1;
                    end else if (clr_en) begin
                        latch_q[p] <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpfs_pad_sync.sv
module gpfs_pad_sync #(
    parameter int WIDTH = 54
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end

endmodule

// File: rtl/gpfs_core.sv
module gpfs_core
    import gpfs_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int PPW      = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] alt_sel
);

    localparam int WIDX_W     = ADDR_W - 2;
    localparam int NUM_BANKS  = (NUM_PINS + DATA_W - 1) / DATA_W;
    localparam int NUM_FWORDS = (NUM_PINS + PPW - 1) / PPW;
    localparam int FIELD_BITS = PPW * FN_W;
    localparam int LEV_BITS   = NUM_BANKS * DATA_W;

    localparam logic [WIDX_W-1:0] FUNC_IDX = WIDX_W'(OFS_FUNC >> 2);
    localparam logic [WIDX_W-1:0] SET_IDX  = WIDX_W'(OFS_SET >> 2);
    localparam logic [WIDX_W-1:0] CLR_IDX  = WIDX_W'(OFS_CLR >> 2);
    localparam logic [WIDX_W-1:0] LEV_IDX  = WIDX_W'(OFS_LEVEL >> 2);
    localparam logic [WIDX_W-1:0] FW_CNT   = WIDX_W'(NUM_FWORDS);
    localparam logic [WIDX_W-1:0] BK_CNT   = WIDX_W'(NUM_BANKS);

    // Address decode. Unaligned accesses match nothing.
    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              func_hit, set_hit, clr_hit;
    logic [WIDX_W-1:0] func_word, out_bank;

    assign widx      = bus_addr[ADDR_W-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign func_hit  = aligned && (widx >= FUNC_IDX) && (widx < FUNC_IDX + FW_CNT);
    assign set_hit   = aligned && (widx >= SET_IDX)  && (widx < SET_IDX + BK_CNT);
    assign clr_hit   = aligned && (widx >= CLR_IDX)  && (widx < CLR_IDX + BK_CNT);
    assign func_word = widx - FUNC_IDX;
    assign out_bank  = set_hit ? (widx - SET_IDX) : (widx - CLR_IDX);

    logic [NUM_FWORDS*DATA_W-1:0] fn_words;
    logic [NUM_PINS-1:0]          oe_mask, alt_mask, latch_q, pad_sync;
    logic [LEV_BITS-1:0]          lev_words;

    gpfs_func_bank #(
        .NUM_PINS  (NUM_PINS),
        .DATA_W    (DATA_W),
        .PPW       (PPW),
        .NUM_FWORDS(NUM_FWORDS),
        .WIDX_W    (WIDX_W)
    ) func_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && func_hit),
        .wr_word  (func_word),
        .wr_fields(bus_wdata[FIELD_BITS-1:0]),
        .rd_words (fn_words),
        .oe_mask  (oe_mask),
        .alt_mask (alt_mask)
    );

    gpfs_out_latch #(
        .NUM_PINS(NUM_PINS),
        .DATA_W  (DATA_W),
        .WIDX_W  (WIDX_W)
    ) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_we && set_hit),
        .clr_en (bus_we && clr_hit),
        .bank   (out_bank),
        .wdata  (bus_wdata),
        .latch_q(latch_q)
    );

    gpfs_pad_sync #(
        .WIDTH(NUM_PINS)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(pad_sync)
    );

    // Level words, zero-filled above the last pin.
    if (LEV_BITS > NUM_PINS) begin : g_lev_pad
        assign lev_words = {{(LEV_BITS - NUM_PINS){1'b0}}, pad_sync};
    end else begin : g_lev_full
        assign lev_words = pad_sync;
    end

    // Pad drive.
    assign pad_oe  = oe_mask;
    assign alt_sel = alt_mask;
    assign pad_out = latch_q & oe_mask;

    // Read path, registered. Write-only and unmapped words return zero.
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (aligned) begin
            for (int w = 0; w < NUM_FWORDS; w++) begin
                if (widx == FUNC_IDX + WIDX_W'(w)) begin
                    rd_next = fn_words[w*DATA_W +: DATA_W];
                end
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (widx == LEV_IDX + WIDX_W'(b)) begin
                    rd_next = lev_words[b*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/gpfs_core_chk.sv
module gpfs_core_chk
    import gpfs_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] alt_sel
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_PADS_IDLE: assert (pad_oe == '0 && pad_out == '0 && alt_sel == '0); // R1
        end
    end

    AST_OE_ALT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & alt_sel) == '0); // R4

    AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R7

    AST_IDLE_PADS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_oe) && $stable(pad_out) && $stable(alt_sel))); // R3

    AST_SET_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_SET)) |=>
        ((~pad_out[DATA_W-1:0] & pad_oe[DATA_W-1:0] & $past(bus_wdata)) == '0)); // R5

    AST_CLR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_CLR)) |=>
        ((pad_out[DATA_W-1:0] & $past(bus_wdata)) == '0)); // R6

    AST_LEVEL_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_LEVEL)) |=>
        ($stable(pad_oe) && $stable(pad_out) && $stable(alt_sel))); // R10

endmodule

bind gpfs_core gpfs_core_chk #(
    .NUM_PINS(NUM_PINS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .alt_sel  (alt_sel)
);

// File: tb/gpfs_core_tb_top.sv
module gpfs_core_tb_top;

    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, alt_sel;

    gpfs_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .alt_sel  (alt_sel)
    );

    always #10 clk = ~clk;

    // Scoreboard.
    typedef struct {
        int          due;
        int          kind;   // 0 rdata, 1 oe, 2 out, 3 alt
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_fails = 0;
    bit    done = 1'b0;

    // Reference model.
    int fn_m[NP];
    bit lat_m[NP];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every item whose cycle has come.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [63:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = {32'b0, bus_rdata};
                1:       act = {10'b0, pad_oe};
                2:       act = {10'b0, pad_out};
                default: act = {10'b0, alt_sel};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fails++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] fword(int w);
        logic [31:0] v = '0;
        for (int k = 0; k < 10; k++) begin
            if (w*10 + k < NP) v[k*3 +: 3] = 3'(fn_m[w*10 + k]);
        end
        return v;
    endfunction

    function automatic logic [63:0] exp_pads(int kind);
        logic [63:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            case (kind)
                1:       v[p] = (fn_m[p] == 1);
                2:       v[p] = (fn_m[p] == 1) && lat_m[p];
                default: v[p] = (fn_m[p] >= 2);
            endcase
        end
        return v;
    endfunction

    task automatic push(int kind, logic [63:0] exp, string tag);
        item_t it;
        it.due = cyc + 1; it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
        bus_addr = a; bus_we = 1'b0;
        push(0, {32'b0, exp}, tag);
        @(negedge clk);
    endtask

    task automatic check_pads(string tag);
        bus_addr = 8'hFC;
        push(1, exp_pads(1), {tag, " oe"});
        push(2, exp_pads(2), {tag, " out"});
        push(3, exp_pads(3), {tag, " alt"});
        @(negedge clk);
    endtask

    task automatic wr_func(int w);
        logic [31:0] d = fword(w) | 32'hC000_0000;
        if (w == 5) d = d | 32'h3FFF_F000;  // junk in absent fields
        bus_write(8'(w*4), d);
    endtask

    task automatic wr_out(bit is_set, int b, logic [31:0] d);
        bus_write(is_set ? 8'(8'h1C + b*4) : 8'(8'h28 + b*4), d);
        for (int i = 0; i < 32; i++) begin
            if (b*32 + i < NP && d[i]) lat_m[b*32 + i] = is_set;
        end
    endtask

    task automatic all_func(int code);
        for (int p = 0; p < NP; p++) fn_m[p] = code;
        for (int w = 0; w < 6; w++) wr_func(w);
    endtask

    task automatic level_check(logic [NP-1:0] pat, string tag);
        pad_in = pat;
        @(negedge clk);
        @(negedge clk);
        bus_read(8'h34, pat[31:0], {tag, " bank0"});
        bus_read(8'h38, {10'b0, pat[53:32]}, {tag, " bank1"});
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin fn_m[p] = 0; lat_m[p] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_pads("R1 reset pads");
        bus_read(8'h00, 32'h0, "R1 reset func word0");
        bus_read(8'h14, 32'h0, "R1 reset func word5");

        // R2 R4: spread every code over the pins
        for (int p = 0; p < NP; p++) fn_m[p] = (p*3 + p/8) % 8;
        for (int w = 0; w < 6; w++) wr_func(w);
        for (int w = 0; w < 6; w++) bus_read(8'(w*4), fword(w), "R2 R9 func readback");
        check_pads("R3 R4 code decode");

        // R5 R7: set all latches
        wr_out(1'b1, 0, 32'hFFFF_FFFF);
        wr_out(1'b1, 1, 32'hFFFF_FFFF);
        check_pads("R5 R7 set all");
        // R6: clear the low half of bank 0
        wr_out(1'b0, 0, 32'h0000_FFFF);
        check_pads("R6 clear low half");
        // R5 R6: zero data has no effect
        wr_out(1'b1, 0, 32'h0);
        wr_out(1'b0, 1, 32'h0);
        check_pads("R5 R6 zero write inert");
        // R6 bank 1 clear of pins 32..35
        wr_out(1'b0, 1, 32'h0000_000F);
        check_pads("R6 bank1 clear");

        // R7: preloaded latches appear when pins 10..19 become outputs
        for (int p = 10; p < 20; p++) fn_m[p] = 1;
        wr_func(1);
        check_pads("R7 preload to output");
        all_func(0);
        check_pads("R7 input hides latch");
        all_func(1);
        check_pads("R7 all output shows latch");

        // R10: ignored writes
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_write(8'h18, 32'h0000_0000);
        bus_write(8'h3C, 32'h0000_0000);
        bus_write(8'h1D, 32'hFFFF_FFFF);
        bus_write(8'h29, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'h0000_0000);
        check_pads("R10 ignored writes pads");
        bus_read(8'h00, fword(0), "R10 ignored writes func word0");

        // R9: write-only, unmapped and unaligned reads give zero
        bus_read(8'h1C, 32'h0, "R9 set reg reads zero");
        bus_read(8'h2C, 32'h0, "R9 clr reg reads zero");
        bus_read(8'h3C, 32'h0, "R9 unmapped reads zero");
        bus_read(8'h02, 32'h0, "R9 unaligned reads zero");

        // R8: level registers through the synchroniser
        level_check(54'h2D_3C4B_5A69_7887, "R8 level pattern A");
        level_check(~54'h2D_3C4B_5A69_7887, "R8 level pattern B");
        level_check('1, "R8 R9 level all ones");

        bus_addr = 8'hFC;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule